// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small processor core. A call writes the program counter value presented on `pc_in` onto the top of the stack. A subroutine return or an interrupt return removes the top entry, and `pc_out` always presents the entry that is currently on top. The stack holds eight entries by default. Both the depth and the address width are parameters.

The block also decides when a pending interrupt is taken. It acknowledges a pending request only when it can store the interrupted address. On the cycle it acknowledges, it stores `pc_in` in the same way a call does. While the stack is full, the request waits without being acknowledged. The first return frees a slot, and the request is then acknowledged. A call on a full stack is still accepted. The oldest entry is overwritten, so the newest eight addresses survive.

Storage is a circular buffer, so dropping the oldest entry costs no data movement. A three-state fill machine tracks occupancy:

| State | Meaning |
|---|---|
| ST_EMPTY | No entries are stored. |
| ST_PARTIAL | Between one and DEPTH-1 entries are stored. |
| ST_FULL | DEPTH entries are stored. |

The machine makes these transitions:

| Transition | Cause |
|---|---|
| ST_EMPTY to ST_PARTIAL | A push. |
| ST_PARTIAL to ST_FULL | A push at level DEPTH-1. |
| ST_PARTIAL to ST_EMPTY | A pop at level 1. |
| ST_FULL to ST_PARTIAL | A pop. |
| ST_FULL to ST_FULL | A push, which overwrites the oldest entry. |
| ST_EMPTY to ST_EMPTY | A pop, which is ignored. |

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the stack: `level` becomes 0 and `full` becomes 0, whatever the other inputs are.
- R2: A push (call strobe or interrupt acknowledge) stores `pc_in` and raises `level` by one at the next edge when the stack is not full. `pc_out` then shows the stored value.
- R3: `full` is 1 exactly when `level` equals DEPTH (8 by default), and 0 at every lower level.
- R4: `irq_ack` is 1 in a cycle exactly when `irq_pending` is 1, `full` is 0, and neither `call_req` nor `ret_req` is 1. An acknowledge pushes `pc_in` at that same edge.
- R5: While `full` is 1, a pending interrupt is not acknowledged and `level` stays at DEPTH. After a return lowers the level, the still-pending request is acknowledged in the next cycle and fills the freed slot.
- R6: A call while full keeps `level` at DEPTH and `full` at 1 and discards the oldest entry. Later returns yield the DEPTH newest addresses, newest first.
- R7: A return on an empty stack leaves `level` at 0 without wrapping. A later push behaves as on a freshly emptied stack.
- R8: A return on a non-empty stack lowers `level` by one at the next edge. `pc_out` then shows the entry pushed just before the removed one.
- R9: When `call_req` and `ret_req` are both 1 in the same cycle, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| call_req | input | 1 | Call strobe: push `pc_in` |
| ret_req | input | 1 | Return strobe (subroutine or interrupt return): pop top entry |
| pc_in | input | PC_W (13) | Address to store on a call or acknowledge |
| pc_out | output | PC_W (13) | Current top entry; undefined while empty |
| irq_pending | input | 1 | An unmasked interrupt request is waiting |
| irq_ack | output | 1 | Interrupt accepted this cycle; `pc_in` is pushed |
| full | output | 1 | Stack holds DEPTH entries |
| level | output | $clog2(DEPTH+1) (4) | Number of stored entries |

## Verification
Assertions check the following on every cycle:

- `level` never exceeds DEPTH.
- `full` agrees with the level counter.
- No acknowledge is issued while the stack is full, without a request, or alongside a call or return strobe.
- `level` moves by exactly one on each accepted push or pop.
- A pop on an empty stack and a push on a full stack leave `level` unchanged.

Only the bench's scenarios can show which addresses come back and in what order. These scenarios cover the following:

- The LIFO order of returned addresses.
- The loss of the oldest entry after an overflowing call.
- The one-cycle delay before a held-off interrupt is taken after a return.
- Recovery from an empty-stack pop.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Occupancy of the return-address stack
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

    // Operation requested of the storage in one cycle
    typedef struct packed {
        logic push;
        logic pop;
    } stack_op_t;

endpackage

// File: rtl/rstk_irq_gate.sv
module rstk_irq_gate
    import rstk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      call_req,
    input  logic      ret_req,
    input  logic      irq_pending,
    input  logic      full,
    output logic      irq_ack,
    output stack_op_t op
);

    // An interrupt is taken only in a cycle free of call/return strobes
    // and only when a slot is available for the interrupted address.
    logic strobe_busy;

    always_comb begin
        strobe_busy = call_req | ret_req;
        irq_ack     = irq_pending & ~full & ~strobe_busy;
        op.push     = call_req | irq_ack;
        op.pop      = ret_req & ~call_req;
    end

    AST_NO_ACK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> !irq_ack); // R5

    AST_ACK_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> irq_pending); // R4

    AST_ACK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (!call_req && !ret_req)); // R4

    AST_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(op.push && op.pop)); // R9

endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stack_op_t        op,
    output logic             full,
    output logic [LVL_W-1:0] level,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] top_idx
);

    localparam logic [LVL_W-1:0] LVL_MAX     = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_NEARMAX = LVL_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_ONE     = LVL_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST    = PTR_W'(DEPTH - 1);
    localparam bit               DEPTH_POW2  = ((DEPTH & (DEPTH - 1)) == 0);

    fill_state_e      state_q, state_d;
    logic [LVL_W-1:0] level_q;
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;
    logic             grow, shrink, is_full, is_empty;

    // Circular pointer arithmetic: free wrap for power-of-two depths,
    // explicit wrap compare otherwise.
    generate
        if (DEPTH_POW2) begin : g_wrap_pow2
            assign ptr_inc = wptr_q + PTR_W'(1);
            assign ptr_dec = wptr_q - PTR_W'(1);
        end else begin : g_wrap_cmp
            assign ptr_inc = (wptr_q == PTR_LAST) ? '0 : wptr_q + PTR_W'(1);
            assign ptr_dec = (wptr_q == '0) ? PTR_LAST : wptr_q - PTR_W'(1);
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (op.push) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (op.push && level_q == LVL_NEARMAX)
                    state_d = ST_FULL;
                else if (op.pop && level_q == LVL_ONE)
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (op.pop) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        is_full  = (state_q == ST_FULL);
        is_empty = (state_q == ST_EMPTY);
        grow     = op.push & ~is_full;
        shrink   = op.pop & ~is_empty;
        full     = is_full;
        level    = level_q;
        wr_en    = op.push;
        wr_idx   = wptr_q;
        top_idx  = ptr_dec;
    end

    // Fill counter: saturates on push when full, holds on pop when empty
    always_ff @(posedge clk) begin
        if (rst)         level_q <= '0;
        else if (grow)   level_q <= level_q + LVL_ONE;
        else if (shrink) level_q <= level_q - LVL_ONE;
    end

    // Write pointer: a push on a full stack lands on the oldest slot
    always_ff @(posedge clk) begin
        if (rst)          wptr_q <= '0;
        else if (op.push) wptr_q <= ptr_inc;
        else if (shrink)  wptr_q <= ptr_dec;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level_q <= LVL_MAX); // R3

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
        is_full == (level_q == LVL_MAX)); // R3

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
        (op.push && level_q != LVL_MAX) |=> level_q == $past(level_q) + LVL_ONE); // R2

    AST_PUSH_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op.push && level_q == LVL_MAX) |=> (level_q == LVL_MAX && is_full)); // R6

    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (op.pop && level_q != '0) |=> level_q == $past(level_q) - LVL_ONE); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (op.pop && level_q == '0) |=> level_q == '0); // R7

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 13,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_data,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [PC_W-1:0]  rd_data
);

    // Plain register file; no reset, contents are meaningful only
    // below the fill level tracked by the controller.
    logic [PC_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_idx] <= wr_data;
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 13,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_req,
    input  logic             ret_req,
    input  logic [PC_W-1:0]  pc_in,
    output logic [PC_W-1:0]  pc_out,
    input  logic             irq_pending,
    output logic             irq_ack,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    stack_op_t        op;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] top_idx;

    rstk_irq_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .irq_pending (irq_pending),
        .full        (full),
        .irq_ack     (irq_ack),
        .op          (op)
    );

    rstk_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .LVL_W (LVL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .full    (full),
        .level   (level),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .top_idx (top_idx)
    );

    rstk_store #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .PTR_W (PTR_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (pc_in),
        .rd_idx  (top_idx),
        .rd_data (pc_out)
    );

    AST_ACK_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> level != '0); // R4

endmodule

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;

    localparam int CLK_PERIOD = 10;
    localparam int PCW   = 13;
    localparam int LVLW  = 4;
    localparam int DEPTH = 8;

    typedef struct packed {
        logic            push;
        logic            pop;
        logic            irq;
        logic [PCW-1:0]  pc;
        logic            ack;
        logic [LVLW-1:0] lvl;
        logic            full;
        logic            chk;
        logic [PCW-1:0]  xpc;
        logic [3:0]      req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 13'h100, 1'b0, 4'd1, 1'b0, 1'b1, 13'h100, 4'd2}, // R2
        '{1'b1, 1'b0, 1'b0, 13'h101, 1'b0, 4'd2, 1'b0, 1'b1, 13'h101, 4'd2}, // R2
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd1, 1'b0, 1'b1, 13'h100, 4'd8}, // R8
        '{1'b0, 1'b0, 1'b1, 13'h222, 1'b1, 4'd2, 1'b0, 1'b1, 13'h222, 4'd4}, // R4
        '{1'b1, 1'b1, 1'b0, 13'h333, 1'b0, 4'd3, 1'b0, 1'b1, 13'h333, 4'd9}, // R9
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd2, 1'b0, 1'b1, 13'h222, 4'd8}, // R8
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd1, 1'b0, 1'b1, 13'h100, 4'd8}, // R8
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd0, 1'b0, 1'b0, 13'h000, 4'd8}, // R8
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd0, 1'b0, 1'b0, 13'h000, 4'd7}, // R7
        '{1'b1, 1'b0, 1'b0, 13'h444, 1'b0, 4'd1, 1'b0, 1'b1, 13'h444, 4'd7}, // R7
        '{1'b1, 1'b0, 1'b1, 13'h555, 1'b0, 4'd2, 1'b0, 1'b1, 13'h555, 4'd4}, // R4
        '{1'b0, 1'b1, 1'b1, 13'h000, 1'b0, 4'd1, 1'b0, 1'b1, 13'h444, 4'd4}, // R4
        '{1'b0, 1'b1, 1'b0, 13'h000, 1'b0, 4'd0, 1'b0, 1'b0, 13'h000, 4'd8}  // R8
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            call_req = 1'b0;
    logic            ret_req = 1'b0;
    logic [PCW-1:0]  pc_in = '0;
    logic [PCW-1:0]  pc_out;
    logic            irq_pending = 1'b0;
    logic            irq_ack;
    logic            full;
    logic [LVLW-1:0] level;

    int   n_checks = 0;
    int   n_errors = 0;
    logic ack_seen;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ret_addr_stack uut (
        .clk         (clk),
        .rst         (rst),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .pc_in       (pc_in),
        .pc_out      (pc_out),
        .irq_pending (irq_pending),
        .irq_ack     (irq_ack),
        .full        (full),
        .level       (level)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, capture the combinational acknowledge
    // before the rising edge, then settle just after the rising edge.
    task automatic step(input logic p, input logic q, input logic i,
                        input logic [PCW-1:0] d);
        @(negedge clk);
        call_req    = p;
        ret_req     = q;
        irq_pending = i;
        pc_in       = d;
        #1 ack_seen = irq_ack;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "level after reset", int'(level), 0);
        check("R1", "full after reset", int'(full), 0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            tag = $sformatf("R%0d", VEC[k].req);
            step(VEC[k].push, VEC[k].pop, VEC[k].irq, VEC[k].pc);
            check(tag, $sformatf("vec%0d ack", k), int'(ack_seen), int'(VEC[k].ack));
            check(tag, $sformatf("vec%0d level", k), int'(level), int'(VEC[k].lvl));
            check(tag, $sformatf("vec%0d full", k), int'(full), int'(VEC[k].full));
            if (VEC[k].chk)
                check(tag, $sformatf("vec%0d pc_out", k), int'(pc_out), int'(VEC[k].xpc));
        end

        // R3: fill to capacity, full only at the last push
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 1'b0, 1'b0, PCW'(13'h10 + k));
            check("R3", $sformatf("full at level %0d", k + 1), int'(full),
                  (k == DEPTH - 1) ? 1 : 0);
        end
        check("R3", "level when full", int'(level), DEPTH);

        // R5: pending interrupt held off while full
        step(1'b0, 1'b0, 1'b1, 13'h0AA);
        check("R5", "ack while full", int'(ack_seen), 0);
        check("R5", "level held while full", int'(level), DEPTH);
        step(1'b0, 1'b0, 1'b1, 13'h0AB);
        check("R5", "ack while full again", int'(ack_seen), 0);

        // R6: call on a full stack overwrites the oldest entry
        step(1'b1, 1'b0, 1'b1, 13'h099);
        check("R6", "ack during call", int'(ack_seen), 0);
        check("R6", "level after overflow call", int'(level), DEPTH);
        check("R6", "full after overflow call", int'(full), 1);
        check("R6", "top after overflow call", int'(pc_out), 'h099);

        // R5: a return frees a slot; the interrupt is taken next cycle
        step(1'b0, 1'b1, 1'b1, 13'h000);
        check("R5", "ack during return", int'(ack_seen), 0);
        check("R5", "level after return", int'(level), DEPTH - 1);
        check("R5", "full after return", int'(full), 0);
        check("R8", "top after return", int'(pc_out), 'h017);
        step(1'b0, 1'b0, 1'b1, 13'h7AA);
        check("R5", "ack after slot freed", int'(ack_seen), 1);
        check("R5", "level after ack", int'(level), DEPTH);
        check("R4", "acknowledged pc stored", int'(pc_out), 'h7AA);

        // R6: drain; oldest entry 0x010 must be gone
        for (int k = 0; k < DEPTH - 1; k++) begin
            step(1'b0, 1'b1, 1'b0, 13'h000);
            check("R6", $sformatf("drain pop %0d top", k), int'(pc_out), 'h17 - k);
            check("R6", $sformatf("drain pop %0d level", k), int'(level), DEPTH - 1 - k);
        end
        step(1'b0, 1'b1, 1'b0, 13'h000);
        check("R6", "level after full drain", int'(level), 0);
        step(1'b0, 1'b1, 1'b0, 13'h000);
        check("R7", "level after extra pop", int'(level), 0);
        check("R7", "full after extra pop", int'(full), 0);

        // R1: reset in the middle of activity, with a push pending
        step(1'b1, 1'b0, 1'b0, 13'h123);
        step(1'b1, 1'b0, 1'b0, 13'h124);
        @(negedge clk);
        rst = 1'b1;
        call_req = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "level after mid-run reset", int'(level), 0);
        check("R1", "full after mid-run reset", int'(full), 0);
        @(negedge clk);
        rst = 1'b0;
        call_req = 1'b0;
        step(1'b1, 1'b0, 1'b0, 13'h1F0);
        check("R2", "push after reset level", int'(level), 1);
        check("R2", "push after reset top", int'(pc_out), 'h1F0);
        step(1'b0, 1'b0, 1'b0, 13'h000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule